// File: doc/BRIEF.md
# BPSK Carrier Synthesizer with Wrap-Aligned Phase Switching

This core makes a digital carrier. A 32-bit phase accumulator adds a frequency tuning word on every clock. The accumulator's upper bits drive a quarter-wave sine table, which gives signed 12-bit samples. A small phase-offset RAM holds one 32-bit phase word per profile. The top bits of each word are the phase, so 0x80000000 is a half turn. A profile-select input can come from another clock domain. It picks which word is added to the accumulator, so a data stream on that input keys the carrier between phases.

With the wrap-aligned mode enabled, a new selection does not take effect at once. It waits until the accumulator carries out of its 32-bit add, meaning it rolls from full scale back to zero. The offset changes in that same cycle, so every phase flip falls on a carrier-cycle boundary. The accumulator itself is never cleared by a selection change.

The tuning word and the mode bit are first written to holding registers. They reach the datapath only when the update strobe is pulsed. The offset RAM is written directly.

Top module: `bpsk_dds_core`

## Requirements
- R1: After reset, the accumulator, the applied offset and the selected (pending) offset are all zero. `phase_out` reads 0, and one clock after reset ends `sample_out` equals the table value for phase 0 (+2).
- R2: Values written with `ftw_wr_en` or `zc_wr_en` do not change the datapath until `io_update` is pulsed. The cycle after the strobe, the held values become active.
- R3: While the applied offset is unchanged, consecutive `phase_out` values differ by exactly the active tuning word, modulo 2^32.
- R4: `sample_out` is within 5 LSB of round(2047·sin(2π·(p+0.5)/4096)), where p is `phase_out[31:20]` one clock earlier. The code -2048 is never produced.
- R5: Profile k applies RAM word k, added in full 32 bits to the accumulator. Word 0x80000000 shifts the carrier by a half turn and 0x40000000 by a quarter turn.
- R6: With the wrap-aligned mode off, a change on `prof_sel_async` first appears in `phase_out` on the fifth rising edge after the input changes. That latency covers two synchronizer stages, the RAM read, the offset register and the output register.
- R7: With the wrap-aligned mode on, a new offset is applied only in a cycle where the accumulator add carries out. The first `phase_out` showing the new offset then satisfies (phase_out − offset) < tuning word.
- R8: With the wrap-aligned mode on, if the selection changes several times between two wraps, only the last selection is applied at the next wrap. A return to the original profile before the wrap produces no phase step.
- R9: A profile change never clears or disturbs the accumulator. At a switch, the step in `phase_out` equals the tuning word plus the difference of the two offset words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw_wr_en | input | 1 | Write the tuning word into its holding register |
| ftw_wr_data | input | 32 | Tuning word value |
| zc_wr_en | input | 1 | Write the wrap-aligned mode bit into its holding register |
| zc_wr_data | input | 1 | 1 = defer offset changes to accumulator wrap |
| io_update | input | 1 | Copy the holding registers into the active configuration |
| ram_wr_en | input | 1 | Write one phase-offset RAM word |
| ram_wr_addr | input | PROF_W | RAM word address (equals profile number) |
| ram_wr_data | input | 32 | Phase word; top bits are the phase |
| prof_sel_async | input | PROF_W | Profile select, may be asynchronous to clk |
| phase_out | output | 32 | Registered accumulator plus applied offset |
| sample_out | output | SAMPLE_W | Registered signed sine sample |

## Verification
The hardest case to reach is a burst of selection changes between two wraps, with the wrap-aligned mode on. To show that only the last one survives, every intermediate selection must clear the synchronizer and the RAM read before the next carry. The bench's monitor raises an event each time it sees the accumulator wrap. The driver waits on that event and then drives the whole burst inside one carrier period of about 20 clocks. Under this stimulus the scoreboard should see exactly one phase step, at the next wrap, whose size matches the last selection only. A second burst that returns to the starting profile must produce no step at all.

// File: rtl/bpsk_dds_pkg.sv
package bpsk_dds_pkg;
  localparam int unsigned ACC_W = 32;

  typedef logic [ACC_W-1:0] phase_t;

  typedef struct packed {
    phase_t ftw;
    logic   zc_en;
  } dds_cfg_t;
endpackage

// File: rtl/bpsk_prof_sync.sv
module bpsk_prof_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta     <= '0;
      sync_out <= '0;
    end else begin
      meta     <= async_in;
      sync_out <= meta;
    end
  end

  // Two clean cycles out of reset: output is the input from two edges back.
  p_sync_two_stage_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(async_in, 2)));
endmodule

// File: rtl/bpsk_phase_ram.sv
module bpsk_phase_ram #(
  parameter int AW = 2,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port; output register reset keeps the pending offset at zero.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/bpsk_phase_acc.sv
module bpsk_phase_acc
  import bpsk_dds_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t ftw,
  output phase_t acc,
  output logic   wrap
);
  phase_t sum;

  assign {wrap, sum} = {1'b0, acc} + {1'b0, ftw};

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= sum;
  end

  // After a carry the accumulator restarts below one step.
  p_wrap_low_r3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (acc < $past(ftw)));
endmodule

// File: rtl/bpsk_sine_lut.sv
module bpsk_sine_lut #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         phase,
  output logic signed [OUT_W-1:0] sample
);
  localparam int     QW     = IN_W - 2;
  localparam int     QDEPTH = 1 << QW;
  localparam int     MAG_W  = OUT_W - 1;
  localparam longint AMP    = (64'sd1 <<< MAG_W) - 1;

  logic [MAG_W-1:0] rom [QDEPTH];

  // Rational sine approximation sampled at the centre of each quarter-wave bin.
  function automatic logic [MAG_W-1:0] quarter_mag(int k);
    longint span = 4 * QDEPTH;
    longint x    = 2 * k + 1;
    longint a    = x * (span - x);
    longint num  = 16 * AMP * a;
    longint den  = 5 * span * span - 4 * a;
    longint v    = (num + den / 2) / den;
    return v[MAG_W-1:0];
  endfunction

  initial begin
    for (int i = 0; i < QDEPTH; i++) rom[i] = quarter_mag(i);
  end

  logic          neg;
  logic [QW-1:0] idx;

  assign neg = phase[IN_W-1];
  assign idx = phase[IN_W-2] ? ~phase[QW-1:0] : phase[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst)      sample <= '0;
    else if (neg) sample <= -$signed({1'b0, rom[idx]});
    else          sample <= $signed({1'b0, rom[idx]});
  end

  p_sample_range_r4: assert property (@(posedge clk) disable iff (rst)
    sample != {1'b1, {MAG_W{1'b0}}});
endmodule

// File: rtl/bpsk_dds_core.sv
module bpsk_dds_core
  import bpsk_dds_pkg::*;
#(
  parameter int PROF_W   = 2,
  parameter int LUT_IN_W = 12,
  parameter int SAMPLE_W = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ftw_wr_en,
  input  logic [ACC_W-1:0]           ftw_wr_data,
  input  logic                       zc_wr_en,
  input  logic                       zc_wr_data,
  input  logic                       io_update,
  input  logic                       ram_wr_en,
  input  logic [PROF_W-1:0]          ram_wr_addr,
  input  logic [ACC_W-1:0]           ram_wr_data,
  input  logic [PROF_W-1:0]          prof_sel_async,
  output logic [ACC_W-1:0]           phase_out,
  output logic signed [SAMPLE_W-1:0] sample_out
);
  localparam int LUT_LSB = ACC_W - LUT_IN_W;

  dds_cfg_t          cfg_hold, cfg_act;
  phase_t            ftw_act;
  logic [PROF_W-1:0] prof_s;
  phase_t            sel_ofs;
  phase_t            active_ofs;
  phase_t            acc;
  logic              acc_wrap;
  phase_t            ph_q;

  // Holding registers; the strobe moves them into the datapath.
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_hold <= '0;
      cfg_act  <= '0;
    end else begin
      if (ftw_wr_en) cfg_hold.ftw   <= ftw_wr_data;
      if (zc_wr_en)  cfg_hold.zc_en <= zc_wr_data;
      if (io_update) cfg_act        <= cfg_hold;
    end
  end

  assign ftw_act = cfg_act.ftw;

  bpsk_prof_sync #(.W(PROF_W)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (prof_sel_async),
    .sync_out (prof_s)
  );

  // Read data register is the pending offset: it always holds the latest selection.
  bpsk_phase_ram #(.AW(PROF_W), .DW(ACC_W)) u_ram (
    .clk   (clk),
    .rst   (rst),
    .we    (ram_wr_en),
    .waddr (ram_wr_addr),
    .wdata (ram_wr_data),
    .raddr (prof_s),
    .rdata (sel_ofs)
  );

  bpsk_phase_acc u_acc (
    .clk  (clk),
    .rst  (rst),
    .ftw  (ftw_act),
    .acc  (acc),
    .wrap (acc_wrap)
  );

  // Deferred application: in wrap-aligned mode only the carry cycle loads the offset.
  always_ff @(posedge clk) begin
    if (rst)                                 active_ofs <= '0;
    else if (!cfg_act.zc_en || acc_wrap)     active_ofs <= sel_ofs;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= acc + active_ofs;
  end

  assign phase_out = ph_q;

  bpsk_sine_lut #(.IN_W(LUT_IN_W), .OUT_W(SAMPLE_W)) u_lut (
    .clk    (clk),
    .rst    (rst),
    .phase  (ph_q[ACC_W-1:LUT_LSB]),
    .sample (sample_out)
  );

  p_reset_clears_r1: assert property (@(posedge clk)
    $past(rst) |-> (active_ofs == '0 && sel_ofs == '0 && ph_q == '0));

  p_hold_until_update_r2: assert property (@(posedge clk) disable iff (rst)
    !io_update |=> $stable(ftw_act));

  p_zc_only_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_act.zc_en) && !$stable(active_ofs)) |-> $past(acc_wrap));
endmodule

// File: tb/tb_bpsk_dds_core.sv
module tb_bpsk_dds_core;
  localparam int PROF_W   = 2;
  localparam int LUT_IN_W = 12;
  localparam int SAMPLE_W = 12;
  localparam int TOL      = 5;
  localparam logic [31:0] FTW_A = 32'h0CCC_CCCD;
  localparam logic [31:0] FTW_B = 32'h0800_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ftw_wr_en = 1'b0;
  logic [31:0] ftw_wr_data = '0;
  logic zc_wr_en = 1'b0;
  logic zc_wr_data = 1'b0;
  logic io_update = 1'b0;
  logic ram_wr_en = 1'b0;
  logic [PROF_W-1:0] ram_wr_addr = '0;
  logic [31:0] ram_wr_data = '0;
  logic [PROF_W-1:0] prof_sel_async = '0;
  logic [31:0] phase_out;
  logic signed [SAMPLE_W-1:0] sample_out;

  bpsk_dds_core #(.PROF_W(PROF_W), .LUT_IN_W(LUT_IN_W), .SAMPLE_W(SAMPLE_W)) dut (
    .clk(clk), .rst(rst),
    .ftw_wr_en(ftw_wr_en), .ftw_wr_data(ftw_wr_data),
    .zc_wr_en(zc_wr_en), .zc_wr_data(zc_wr_data),
    .io_update(io_update),
    .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
    .prof_sel_async(prof_sel_async),
    .phase_out(phase_out), .sample_out(sample_out)
  );

  always #2 clk = ~clk;

  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] delta;
    int unsigned at;
    bit          zc;
  } exp_t;
  exp_t exp_q[$];

  bit          mon_en    = 1'b0;
  bit          have_prev = 1'b0;
  logic [31:0] prev_ph   = '0;
  logic [31:0] mon_ftw   = '0;
  logic [31:0] mon_ofs   = '0;
  event        wrap_ev;

  logic [31:0] words [4];
  logic [31:0] drv_ofs = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int sine_ref(logic [31:0] ph);
    real ang = 2.0 * 3.14159265358979 * (real'(ph >> (32 - LUT_IN_W)) + 0.5)
               / real'(1 << LUT_IN_W);
    real v = 2047.0 * $sin(ang);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  // Monitor: pops expected phase steps and compares them as they appear.
  always @(negedge clk) begin
    logic [31:0] d;
    int e;
    int a;
    exp_t it;
    if (mon_en) begin
      if (have_prev) begin
        e = sine_ref(prev_ph);
        a = sample_out;
        chk((a - e <= TOL) && (e - a <= TOL), "R4", "sine sample", a, e);
        d = phase_out - prev_ph;
        if (d == mon_ftw) begin
          chk(1'b1, "R3", "step", d, mon_ftw);
        end else if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected phase step", d, mon_ftw);
        end else begin
          it = exp_q.pop_front();
          chk(d == mon_ftw + it.delta, "R5 R9", "switch step", d, mon_ftw + it.delta);
          mon_ofs = mon_ofs + it.delta;
          if (it.zc) begin
            chk(cyc >= it.at, "R7", "applied too early", cyc, it.at);
            chk((phase_out - mon_ofs) < mon_ftw, "R7", "switch not at wrap",
                phase_out - mon_ofs, mon_ftw);
          end else begin
            chk(cyc == it.at, "R6", "switch latency", cyc, it.at);
          end
        end
        if ((phase_out - mon_ofs) < mon_ftw) -> wrap_ev;
      end
      prev_ph   = phase_out;
      have_prev = 1'b1;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_update();
    io_update = 1'b1;
    tick(1);
    io_update = 1'b0;
  endtask

  // Driver: changes the profile pins and queues the expected step.
  task automatic select(logic [PROF_W-1:0] p, bit zc);
    exp_t it;
    prof_sel_async = p;
    it.delta = words[p] - drv_ofs;
    it.at    = cyc + 5;
    it.zc    = zc;
    drv_ofs  = words[p];
    exp_q.push_back(it);
  endtask

  initial begin
    words[0] = 32'h0000_0000;
    words[1] = 32'h8000_0000;
    words[2] = 32'h4000_0000;
    words[3] = 32'hC000_0000;

    tick(5);
    rst = 1'b0;
    tick(1);
    chk(phase_out == 32'h0, "R1", "phase after reset", phase_out, 0);
    chk(int'(sample_out) == 2, "R1", "sample after reset", sample_out, 2);

    for (int i = 0; i < 4; i++) begin
      ram_wr_en = 1'b1; ram_wr_addr = PROF_W'(i); ram_wr_data = words[i];
      tick(1);
    end
    ram_wr_en = 1'b0;

    ftw_wr_en = 1'b1; ftw_wr_data = FTW_A;
    tick(1);
    ftw_wr_en = 1'b0;
    tick(8);
    chk(phase_out == 32'h0, "R2", "tuning word active before update", phase_out, 0);

    pulse_update();
    tick(3);
    chk(phase_out != 32'h0, "R2", "accumulator idle after update", phase_out, 1);
    mon_ftw = FTW_A; mon_ofs = '0; have_prev = 1'b0; mon_en = 1'b1;
    tick(30);

    // Immediate mode: every selection lands five edges later.
    select(2'd1, 1'b0); tick(12);
    select(2'd2, 1'b0); tick(12);
    select(2'd3, 1'b0); tick(7);
    select(2'd0, 1'b0); tick(12);
    select(2'd1, 1'b0); tick(12);
    chk(exp_q.size() == 0, "R6", "pending immediate switches", exp_q.size(), 0);

    zc_wr_en = 1'b1; zc_wr_data = 1'b1;
    tick(1);
    zc_wr_en = 1'b0;
    pulse_update();
    tick(3);

    // Wrap-aligned mode: selections at several points in the carrier period.
    for (int k = 0; k < 6; k++) begin
      @(wrap_ev);
      tick(k * 3);
      select(PROF_W'((k % 3) + (k % 3 >= 1 ? 1 : 0) + 0) ^ 2'd0, 1'b1);
      tick(45);
    end
    chk(exp_q.size() == 0, "R7", "pending deferred switches", exp_q.size(), 0);

    // Burst between two wraps: only the last selection counts.
    @(wrap_ev);
    prof_sel_async = (drv_ofs == words[2]) ? 2'd1 : 2'd2;
    tick(2);
    prof_sel_async = 2'd0;
    tick(2);
    select((drv_ofs == words[3]) ? 2'd1 : 2'd3, 1'b1);
    tick(45);
    chk(mon_ofs == drv_ofs, "R8", "offset after burst", mon_ofs, drv_ofs);

    // Burst that returns to the starting profile: no step at all.
    @(wrap_ev);
    prof_sel_async = (drv_ofs == words[0]) ? 2'd1 : 2'd0;
    tick(2);
    prof_sel_async = (drv_ofs == words[3]) ? 2'd3 : 2'd1;
    tick(45);
    chk(mon_ofs == drv_ofs, "R8", "offset after return burst", mon_ofs, drv_ofs);

    // New tuning word held until the strobe.
    ftw_wr_en = 1'b1; ftw_wr_data = FTW_B;
    tick(1);
    ftw_wr_en = 1'b0;
    tick(10);
    mon_en = 1'b0;
    pulse_update();
    tick(3);
    mon_ftw = FTW_B; have_prev = 1'b0; mon_en = 1'b1;
    tick(5);
    @(wrap_ev);
    tick(4);
    select((drv_ofs == words[2]) ? 2'd0 : 2'd2, 1'b1);
    tick(80);

    chk(exp_q.size() == 0, "R7", "pending switches at end", exp_q.size(), 0);
    chk(mon_ofs == drv_ofs, "R9", "final offset", mon_ofs, drv_ofs);

    mon_en = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R3 watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule